// File: doc/BRIEF.md
# Flash Status and Identification Read Responder

This block answers the read cycles of a NAND flash device model while the last command was a status query or an identification query. A command latch upstream decodes the command byte and gives the block one single-cycle strobe for a status query, an identification query, a device reset, or any other command. The block keeps the status byte, tracks the write-protect pin and presents read data on the I/O bus one clock after each read strobe.

After a status query every read returns the current status byte and nothing advances, until the next command strobe. After an identification query, successive reads step through four bytes: the manufacturer code, the device code, a filler byte and a geometry byte. The geometry byte tells a host whether the part has large or small pages and, for large pages, whether the bus is 8 or 16 bits wide. When chip enable is high, or when there is nothing left to give, a read returns zero. The page-data path and the array are handled elsewhere.

Top module: `nand_query_responder`

## Requirements
- R1: While reset is asserted and after it, rd_data is 0; a read strobe with no status or identification query pending returns 0.
- R2: In a status read, bit 7 of the returned byte equals wp_n in the cycle of the read strobe (1 = writes allowed, 0 = protected).
- R3: After hardware reset or a reset command, the status byte has bit 6 (ready) set and bits 5 to 0 (error in bit 0, plane flags in bits 1 to 4, bit 5 reserved) cleared, so a status read returns 0x40 with bit 7 from R2.
- R4: After a status query, every read strobe returns the status byte again with no pointer movement, until the next command strobe of any kind.
- R5: After an identification query, reads return in turn MFR_ID, DEV_ID, FILL_BYTE (default 0x51) and the geometry byte, one byte per read strobe; every further read returns 0.
- R6: The geometry byte is 0x15 for a large-page part with an 8-bit bus, 0x55 for a large-page part with a 16-bit bus and 0xC0 for a small-page part.
- R7: A read strobe while ce_n is high returns 0 and does not advance the identification sequence.
- R8: rd_data changes only in the clock after a read strobe and holds otherwise; with a 16-bit bus the value sits in bits 7 to 0 and bits 15 to 8 are 0.
- R9: When several command strobes coincide, reset wins over identification, which wins over status, which wins over other; any command strobe ends the previous query, and a read strobe in the same cycle as a command strobe returns 0.
- R10: A new identification query restarts the sequence at the manufacturer byte, whatever position the previous one had reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| wp_n | input | 1 | Write-protect pin, low protects |
| cmd_reset_stb | input | 1 | Reset command decoded |
| cmd_id_stb | input | 1 | Identification query decoded |
| cmd_status_stb | input | 1 | Status query decoded |
| cmd_other_stb | input | 1 | Any other command decoded |
| rd_stb | input | 1 | Read cycle on the I/O bus |
| rd_data | output | 8 or 16 | Registered read data; 16 when BUS16 is set |

## Verification
The bench drives one stimulus stream into two copies of the block: one built as a large-page part with a 16-bit bus and one as a small-page part with an 8-bit bus. With these two builds, two of the three geometry byte encodings are checked, and so are the zero upper byte on the wide bus and the unpadded narrow output. Both builds take different manufacturer and device codes, so a swapped or stuck identification byte shows in at least one of them. Write-protect toggles during repeated status reads, coincident command strobes and reads with chip enable high are all exercised against the behavioural model.

// File: rtl/nand_query_pkg.sv
package nand_query_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_STAT = 2'd1,
        MODE_ID   = 2'd2
    } rsp_mode_e;

    localparam int ID_LEN    = 4;
    localparam int IDX_W     = $clog2(ID_LEN + 1);
    localparam int STAT_RDY  = 6;
    localparam int STAT_UNPR = 7;

    typedef struct packed {
        rsp_mode_e  mode;
        logic [7:0] data;
    } rsp_state_t;

    function automatic logic [7:0] geometry_byte(input bit large_page, input bit bus16);
        if (!large_page) return 8'hC0;
        return bus16 ? 8'h55 : 8'h15;
    endfunction

endpackage

// File: rtl/nand_status_reg.sv
module nand_status_reg
    import nand_query_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp_n,
    input  logic       clr_stb,
    output logic [7:0] stat_d
);
    logic [7:0] stat_q;

    always_comb begin
        stat_d = stat_q;
        if (clr_stb) begin
            stat_d           = '0;
            stat_d[STAT_RDY] = 1'b1;
        end
        stat_d[STAT_UNPR] = wp_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q           <= '0;
            stat_q[STAT_RDY] <= 1'b1;
        end else begin
            stat_q <= stat_d;
        end
    end
endmodule

// File: rtl/nand_id_seq.sv
module nand_id_seq
    import nand_query_pkg::*;
#(
    parameter logic [7:0] MFR_ID     = 8'hEC,
    parameter logic [7:0] DEV_ID     = 8'hF1,
    parameter logic [7:0] FILL_BYTE  = 8'h51,
    parameter bit         LARGE_PAGE = 1'b1,
    parameter bit         BUS16      = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       advance,
    output logic [7:0] id_byte,
    output logic       id_valid
);
    localparam logic [7:0] TAIL = geometry_byte(LARGE_PAGE, BUS16);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (restart)
            idx_d = '0;
        else if (advance && id_valid)
            idx_d = idx_q + 1'b1;
    end

    always_comb begin
        id_valid = (idx_q < IDX_W'(ID_LEN));
        case (idx_q)
            IDX_W'(0): id_byte = MFR_ID;
            IDX_W'(1): id_byte = DEV_ID;
            IDX_W'(2): id_byte = FILL_BYTE;
            IDX_W'(3): id_byte = TAIL;
            default:   id_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= IDX_W'(ID_LEN);
        else        idx_q <= idx_d;
    end
endmodule

// File: rtl/nand_query_responder.sv
module nand_query_responder
    import nand_query_pkg::*;
#(
    parameter logic [7:0] MFR_ID     = 8'hEC,
    parameter logic [7:0] DEV_ID     = 8'hF1,
    parameter logic [7:0] FILL_BYTE  = 8'h51,
    parameter bit         LARGE_PAGE = 1'b1,
    parameter bit         BUS16      = 1'b0,
    localparam int        OUT_W      = BUS16 ? 16 : 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             wp_n,
    input  logic             cmd_reset_stb,
    input  logic             cmd_id_stb,
    input  logic             cmd_status_stb,
    input  logic             cmd_other_stb,
    input  logic             rd_stb,
    output logic [OUT_W-1:0] rd_data
);
    rsp_state_t st_d, st_q;
    rsp_mode_e  mode_q;
    logic [7:0] stat_next;
    logic [7:0] id_byte;
    logic       id_valid;
    logic       any_cmd;
    logic       rd_live;
    logic       id_adv;

    assign mode_q  = st_q.mode;
    assign any_cmd = cmd_reset_stb | cmd_id_stb | cmd_status_stb | cmd_other_stb;
    assign rd_live = rd_stb & ~ce_n & ~any_cmd;
    assign id_adv  = rd_live & (st_q.mode == MODE_ID);

    nand_status_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wp_n    (wp_n),
        .clr_stb (cmd_reset_stb),
        .stat_d  (stat_next)
    );

    nand_id_seq #(
        .MFR_ID     (MFR_ID),
        .DEV_ID     (DEV_ID),
        .FILL_BYTE  (FILL_BYTE),
        .LARGE_PAGE (LARGE_PAGE),
        .BUS16      (BUS16)
    ) u_id (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cmd_id_stb & ~cmd_reset_stb),
        .advance  (id_adv),
        .id_byte  (id_byte),
        .id_valid (id_valid)
    );

    always_comb begin
        st_d = st_q;
        if (rd_stb) begin
            st_d.data = 8'h00;
            if (rd_live) begin
                case (st_q.mode)
                    MODE_STAT: st_d.data = stat_next;
                    MODE_ID:   st_d.data = id_valid ? id_byte : 8'h00;
                    default:   st_d.data = 8'h00;
                endcase
            end
        end
        if (cmd_reset_stb)       st_d.mode = MODE_IDLE;
        else if (cmd_id_stb)     st_d.mode = MODE_ID;
        else if (cmd_status_stb) st_d.mode = MODE_STAT;
        else if (cmd_other_stb)  st_d.mode = MODE_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_IDLE;
            st_q.data <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (BUS16) begin : g_wide
            assign rd_data = {8'h00, st_q.data};
        end else begin : g_narrow
            assign rd_data = st_q.data;
        end
    endgenerate
endmodule

// File: rtl/nand_query_checker.sv
module nand_query_checker
    import nand_query_pkg::*;
#(
    parameter int OUT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             wp_n,
    input logic             cmd_reset_stb,
    input logic             cmd_id_stb,
    input logic             cmd_status_stb,
    input logic             cmd_other_stb,
    input logic             rd_stb,
    input rsp_mode_e        mode_q,
    input logic [OUT_W-1:0] rd_data
);
    logic cmd_seen;
    logic stat_read;
    assign cmd_seen  = cmd_reset_stb | cmd_id_stb | cmd_status_stb | cmd_other_stb;
    assign stat_read = rd_stb & ~ce_n & ~cmd_seen & (mode_q == MODE_STAT);

    assert_idle_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && mode_q == MODE_IDLE |=> rd_data == '0);

    assert_wp_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_read |=> rd_data[7] == $past(wp_n));

    assert_ready_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_read |=> rd_data[6:0] == 7'h40);

    assert_ce_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && ce_n |=> rd_data == '0);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    assert_cmd_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && cmd_seen |=> rd_data == '0);

    assert_reset_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset_stb |=> mode_q == MODE_IDLE);

    generate
        if (OUT_W > 8) begin : g_upper
            assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
                rd_stb |=> rd_data[OUT_W-1:8] == '0);
        end
    endgenerate
endmodule

bind nand_query_responder nand_query_checker #(.OUT_W(OUT_W)) u_query_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ce_n           (ce_n),
    .wp_n           (wp_n),
    .cmd_reset_stb  (cmd_reset_stb),
    .cmd_id_stb     (cmd_id_stb),
    .cmd_status_stb (cmd_status_stb),
    .cmd_other_stb  (cmd_other_stb),
    .rd_stb         (rd_stb),
    .mode_q         (mode_q),
    .rd_data        (rd_data)
);

// File: tb/tb_nand_query_responder.sv
module tb_nand_query_responder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b0, wp_n = 1'b1;
    logic c_rst = 1'b0, c_id = 1'b0, c_st = 1'b0, c_ot = 1'b0, rd = 1'b0;
    logic [15:0] out_lp;
    logic [7:0]  out_sp;

    always #5 clk = ~clk;

    nand_query_responder #(.MFR_ID(8'hEC), .DEV_ID(8'hF1), .LARGE_PAGE(1'b1), .BUS16(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wp_n(wp_n),
        .cmd_reset_stb(c_rst), .cmd_id_stb(c_id), .cmd_status_stb(c_st),
        .cmd_other_stb(c_ot), .rd_stb(rd), .rd_data(out_lp));

    nand_query_responder #(.MFR_ID(8'h2C), .DEV_ID(8'h75), .LARGE_PAGE(1'b0), .BUS16(1'b0)) dut_sp (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wp_n(wp_n),
        .cmd_reset_stb(c_rst), .cmd_id_stb(c_id), .cmd_status_stb(c_st),
        .cmd_other_stb(c_ot), .rd_stb(rd), .rd_data(out_sp));

    // behavioural reference: 0 idle, 1 status, 2 id
    int   m_mode = 0;
    int   m_idx  = 0;
    logic [15:0] exp_lp = '0;
    logic [7:0]  exp_sp = '0;
    int   vectors = 0, miscompares = 0, cycles = 0;
    string phase = "R1";
    bit   done = 0;

    function automatic logic [7:0] id_at(int i, logic [7:0] m, logic [7:0] d, logic [7:0] g);
        case (i)
            0: return m;
            1: return d;
            2: return 8'h51;
            3: return g;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_idx = 4; exp_lp = '0; exp_sp = '0;
        end else begin
            if (rd) begin
                exp_lp = '0; exp_sp = '0;
                if (!ce_n && !(c_rst || c_id || c_st || c_ot)) begin
                    if (m_mode == 1) begin
                        exp_lp = {8'h00, wp_n, 7'h40};
                        exp_sp = {wp_n, 7'h40};
                    end else if (m_mode == 2 && m_idx < 4) begin
                        exp_lp = {8'h00, id_at(m_idx, 8'hEC, 8'hF1, 8'h55)};
                        exp_sp = id_at(m_idx, 8'h2C, 8'h75, 8'hC0);
                        m_idx++;
                    end
                end
            end
            if (c_rst)     m_mode = 0;
            else if (c_id) begin m_mode = 2; m_idx = 0; end
            else if (c_st) m_mode = 1;
            else if (c_ot) m_mode = 0;
        end
    end

    always @(posedge clk) begin
        #3;
        cycles++;
        if (!done) begin
            vectors++;
            if (out_lp !== exp_lp) begin
                miscompares++;
                $display("FAIL %s wide/large-page: got %h expected %h at %0t", phase, out_lp, exp_lp, $time);
            end
            if (out_sp !== exp_sp) begin
                miscompares++;
                $display("FAIL %s narrow/small-page: got %h expected %h at %0t", phase, out_sp, exp_sp, $time);
            end
            if (cycles > 5000) begin
                miscompares++;
                $display("FAIL watchdog expired");
                done = 1;
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    task automatic step(input logic r_, input logic i_, input logic s_, input logic o_,
                        input logic rd_, input logic ce_);
        @(negedge clk);
        c_rst = r_; c_id = i_; c_st = s_; c_ot = o_; rd = rd_; ce_n = ce_;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic reads(input int n, input logic ce_);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 1, ce_);
    endtask

    initial begin
        phase = "R1";
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        reads(2, 0);
        idle(1);

        phase = "R3";
        step(0, 0, 1, 0, 0, 0);
        reads(1, 0);
        phase = "R4";
        reads(3, 0);
        phase = "R2";
        @(negedge clk) wp_n = 1'b0;
        reads(2, 0);
        @(negedge clk) wp_n = 1'b1;
        reads(1, 0);

        phase = "R9";
        step(0, 0, 0, 1, 0, 0);
        reads(2, 0);

        phase = "R5";
        step(0, 1, 0, 0, 0, 0);
        reads(4, 0);
        idle(2);
        reads(2, 0);
        phase = "R6";
        step(0, 1, 0, 0, 0, 0);
        reads(4, 0);

        phase = "R7";
        step(0, 1, 0, 0, 0, 0);
        reads(3, 1);
        reads(2, 0);
        reads(1, 1);
        reads(3, 0);

        phase = "R10";
        step(0, 1, 0, 0, 0, 0);
        reads(2, 0);
        step(0, 1, 0, 0, 0, 0);
        reads(2, 0);

        phase = "R9";
        step(0, 0, 1, 0, 1, 0);
        reads(1, 0);
        step(1, 1, 1, 0, 0, 0);
        reads(2, 0);
        step(0, 1, 1, 1, 0, 0);
        reads(2, 0);
        step(0, 0, 1, 1, 0, 0);
        reads(1, 0);

        phase = "R3";
        @(negedge clk) wp_n = 1'b0;
        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        reads(2, 0);
        @(negedge clk) wp_n = 1'b1;

        phase = "R8";
        step(0, 1, 0, 0, 0, 0);
        reads(1, 0);
        idle(4);
        reads(1, 0);
        idle(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule